// File: doc/BRIEF.md
# Word-Aligned Two-Word Instruction Fetcher

This block sits at the front of a small processor pipeline. It keeps a byte-addressed program counter that always points at an even address, presents that address to program memory, and receives each 16-bit instruction word the same cycle. A word's low byte lives at the even address and its high byte at the next odd address. Because every instruction word is two bytes long, the counter moves in steps of two.

Instructions are one or two words long. When the decoder marks a first word as the start of a two-word instruction, the fetcher holds it and collects the following word before it reports the instruction as complete. A valid second word has the marker nibble `4'hF` in bits 15:12. The fetcher flags a second word that lacks this marker.

The fetcher also handles redirects from the decoder:

- **Absolute jump.** The 20-bit word address is spread over the two words of the instruction held in the fetcher. The fetcher rebuilds it and writes it into program counter bits 20:1.
- **Relative branch.** The fetcher adds a signed word count, doubled into bytes, to the counter. At that point the counter already points past the branch instruction.

Top module: `ifetch_unit`

## Requirements
- R1: While `rstN` is low and on the first cycle after release, `memAddr`, `word0`, `word1`, `instValid` and `pairErr` are all zero.
- R2: `memAddr` bit 0 is always zero. Each accepted word fetch (`fetchReq` high, no redirect) advances `memAddr` by exactly 2, modulo 2^21.
- R3: A fetch in first-word state with `twoWord` low loads `memData` into `word0` and clears `word1`. `instValid` is then high for exactly the next cycle.
- R4: A fetch in first-word state with `twoWord` high loads `word0` and does not raise `instValid`. The next fetch loads `word1` from `memData`. `instValid` is high the cycle after that fetch.
- R5: `pairErr` is 1 when the captured second word's bits 15:12 differ from `4'hF`, and 0 when they equal `4'hF` or the instruction is one word long.
- R6: `jumpAbs` loads `memAddr` with `{word1[11:0], word0[7:0], 1'b0}`. For example, words `EF03h` then `F000h` give byte address `000006h`.
- R7: `branchRel` loads `memAddr` with `memAddr + 2*sext(branchOff)`, where `branchOff` is an 11-bit two's-complement count of words, and the sum wraps modulo 2^21.
- R8: Priority is `jumpAbs` over `branchRel` over `fetchReq`. A redirect raises no `instValid` on the next cycle and drops any pending second-word wait, so the next fetch is treated as a first word.
- R9: `pcNext` always equals the value `memAddr` takes at the next clock edge.
- R10: With `fetchReq`, `jumpAbs` and `branchRel` all low, `memAddr`, `word0`, `word1` and `pairErr` hold, and `instValid` is 0 the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memData | input | 16 | Instruction word read at `memAddr` |
| fetchReq | input | 1 | Accept `memData` and advance to the next word |
| twoWord | input | 1 | Current first word begins a two-word instruction |
| jumpAbs | input | 1 | Redirect to the absolute target held in `word0`/`word1` |
| branchRel | input | 1 | Redirect by a signed word offset |
| branchOff | input | 11 | Signed branch offset in words |
| memAddr | output | 21 | Even byte address of the word being read |
| pcNext | output | 21 | Program counter value after the next edge |
| word0 | output | 16 | First word of the last instruction |
| word1 | output | 16 | Second word, zero for a one-word instruction |
| instValid | output | 1 | One-cycle pulse: `word0`/`word1` hold a complete instruction |
| pairErr | output | 1 | Second word lacks the `4'hF` marker |

## Verification
The bench sweeps all 2048 branch offsets from a range of starting counters. This catches three classes of error:

- An offset left unscaled, or zero-extended instead of sign-extended, lands short or on the wrong side, and the counter no longer wraps through zero correctly.
- Absolute targets are built from many low-byte/high-field pairs. Swapped fields or a missing shift would produce odd or misplaced addresses.
- Mixed runs of one- and two-word fetches with idle gaps expose a fetcher that emits after the first half of a pair, fails to clear the second word, or advances while idle.

Requests that hit all three controls at once, and redirects issued in the middle of a pair, show whether priority is wrong or a stale second-word wait survives.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  // value of bits 15:12 that marks the second word of a pair
  localparam logic [3:0] PAIR_MARK = 4'hF;

  typedef enum logic {
    ST_FIRST  = 1'b0,
    ST_SECOND = 1'b1
  } fetch_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capLo;    // load first word, clear second
    logic capHi;    // load second word
    logic incPc;    // step counter by one word
    logic loadAbs;  // absolute redirect
    logic loadRel;  // relative redirect
    logic emit;     // instruction complete
  } fetch_strobe_t;

endpackage

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchReq,
  input  logic          twoWord,
  input  logic          jumpAbs,
  input  logic          branchRel,
  output fetch_strobe_t strobe
);

  fetch_state_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (jumpAbs) begin
      strobe.loadAbs = 1'b1;
      stateNext      = ST_FIRST;
    end else if (branchRel) begin
      strobe.loadRel = 1'b1;
      stateNext      = ST_FIRST;
    end else if (fetchReq) begin
      strobe.incPc = 1'b1;
      if (state == ST_FIRST) begin
        strobe.capLo = 1'b1;
        if (twoWord) begin
          stateNext = ST_SECOND;
        end else begin
          strobe.emit = 1'b1;
        end
      end else begin
        strobe.capHi = 1'b1;
        strobe.emit  = 1'b1;
        stateNext    = ST_FIRST;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FIRST;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ifetch_dp.sv
module ifetch_dp
  import ifetch_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int HI_BITS   = 12,
  parameter int LO_BITS   = 8,
  parameter int OFF_W     = 11,
  localparam int PC_W     = HI_BITS + LO_BITS + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fetch_strobe_t        strobe,
  input  logic [WORD_BITS-1:0] memData,
  input  logic [OFF_W-1:0]     branchOff,
  output logic [PC_W-1:0]      pc,
  output logic [PC_W-1:0]      pcNext,
  output logic [WORD_BITS-1:0] wordLo,
  output logic [WORD_BITS-1:0] wordHi,
  output logic                 valid,
  output logic                 hiBad
);

  localparam int EXT_W = PC_W - OFF_W - 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] absTgt;
  logic [PC_W-1:0] relDelta;
  logic [PC_W-1:0] relTgt;

  assign absTgt   = {wordHi[HI_BITS-1:0], wordLo[LO_BITS-1:0], 1'b0};
  assign relDelta = {{EXT_W{branchOff[OFF_W-1]}}, branchOff, 1'b0};
  assign relTgt   = pc + relDelta;

  always_comb begin
    pcNext = pc;
    if (strobe.loadAbs)      pcNext = absTgt;
    else if (strobe.loadRel) pcNext = relTgt;
    else if (strobe.incPc)   pcNext = pc + STEP;
    pcNext[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      wordLo <= '0;
      wordHi <= '0;
      valid  <= 1'b0;
      hiBad  <= 1'b0;
    end else begin
      pc    <= pcNext;
      valid <= strobe.emit;
      if (strobe.capLo) begin
        wordLo <= memData;
        wordHi <= '0;
        hiBad  <= 1'b0;
      end else if (strobe.capHi) begin
        wordHi <= memData;
        hiBad  <= (memData[WORD_BITS-1 -: 4] != PAIR_MARK);
      end
    end
  end

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifetch_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int HI_BITS   = 12,
  parameter int LO_BITS   = 8,
  parameter int OFF_W     = 11,
  localparam int PC_W     = HI_BITS + LO_BITS + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] memData,
  input  logic                 fetchReq,
  input  logic                 twoWord,
  input  logic                 jumpAbs,
  input  logic                 branchRel,
  input  logic [OFF_W-1:0]     branchOff,
  output logic [PC_W-1:0]      memAddr,
  output logic [PC_W-1:0]      pcNext,
  output logic [WORD_BITS-1:0] word0,
  output logic [WORD_BITS-1:0] word1,
  output logic                 instValid,
  output logic                 pairErr
);

  fetch_strobe_t strobe;

  ifetch_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchReq  (fetchReq),
    .twoWord   (twoWord),
    .jumpAbs   (jumpAbs),
    .branchRel (branchRel),
    .strobe    (strobe)
  );

  ifetch_dp #(
    .WORD_BITS (WORD_BITS),
    .HI_BITS   (HI_BITS),
    .LO_BITS   (LO_BITS),
    .OFF_W     (OFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memData   (memData),
    .branchOff (branchOff),
    .pc        (memAddr),
    .pcNext    (pcNext),
    .wordLo    (word0),
    .wordHi    (word1),
    .valid     (instValid),
    .hiBad     (pairErr)
  );

endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
  parameter int WORD_BITS = 16,
  parameter int HI_BITS   = 12,
  parameter int LO_BITS   = 8,
  parameter int OFF_W     = 11,
  localparam int PC_W     = HI_BITS + LO_BITS + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 fetchReq,
  input logic                 jumpAbs,
  input logic                 branchRel,
  input logic [PC_W-1:0]      memAddr,
  input logic [PC_W-1:0]      pcNext,
  input logic [WORD_BITS-1:0] word0,
  input logic [WORD_BITS-1:0] word1,
  input logic                 instValid,
  input logic                 pairErr
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r2_addr_even: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[0] == 1'b0);

  a_r2_step_two: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (fetchReq && !jumpAbs && !branchRel) |=> memAddr == $past(memAddr) + PC_W'(2));

  a_r9_next_matches: assert property (@(posedge clk) disable iff (!rstN || !armed)
    1'b1 |=> memAddr == $past(pcNext));

  a_r6_abs_target: assert property (@(posedge clk) disable iff (!rstN || !armed)
    jumpAbs |=> memAddr == {$past(word1[HI_BITS-1:0]), $past(word0[LO_BITS-1:0]), 1'b0});

  a_r8_redirect_quiet: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (jumpAbs || branchRel) |=> !instValid);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!fetchReq && !jumpAbs && !branchRel) |=>
      ($stable(memAddr) && $stable(word0) && $stable(word1) && $stable(pairErr) && !instValid));

endmodule

bind ifetch_unit ifetch_unit_chk #(
  .WORD_BITS (WORD_BITS),
  .HI_BITS   (HI_BITS),
  .LO_BITS   (LO_BITS),
  .OFF_W     (OFF_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchReq  (fetchReq),
  .jumpAbs   (jumpAbs),
  .branchRel (branchRel),
  .memAddr   (memAddr),
  .pcNext    (pcNext),
  .word0     (word0),
  .word1     (word1),
  .instValid (instValid),
  .pairErr   (pairErr)
);

// File: tb/ifetch_unit_bench.sv
module ifetch_unit_bench;

  localparam int PC_W = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memData = '0;
  logic        fetchReq = 1'b0;
  logic        twoWord = 1'b0;
  logic        jumpAbs = 1'b0;
  logic        branchRel = 1'b0;
  logic [10:0] branchOff = '0;
  logic [PC_W-1:0] memAddr, pcNext;
  logic [15:0] word0, word1;
  logic        instValid, pairErr;

  always #4 clk = ~clk;

  ifetch_unit u_ifetch_unit (
    .clk(clk), .rstN(rstN), .memData(memData), .fetchReq(fetchReq),
    .twoWord(twoWord), .jumpAbs(jumpAbs), .branchRel(branchRel),
    .branchOff(branchOff), .memAddr(memAddr), .pcNext(pcNext),
    .word0(word0), .word1(word1), .instValid(instValid), .pairErr(pairErr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the expected state
  logic [PC_W-1:0] mPc = '0;
  logic [15:0]     mW0 = '0;
  logic [15:0]     mW1 = '0;
  logic            mBad = 1'b0;
  logic            mSecond = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic tw, input logic ja, input logic br,
                      input logic [10:0] off, input logic [15:0] d, input string tag);
    logic [PC_W-1:0] expPc;
    logic expValid;
    logic [PC_W-1:0] delta;
    expValid = 1'b0;
    delta = {{9{off[10]}}, off, 1'b0};
    if (ja)      expPc = {mW1[11:0], mW0[7:0], 1'b0};
    else if (br) expPc = mPc + delta;
    else if (fr) expPc = mPc + PC_W'(2);
    else         expPc = mPc;
    @(negedge clk);
    fetchReq = fr; twoWord = tw; jumpAbs = ja; branchRel = br;
    branchOff = off; memData = d;
    #1;
    chk({tag, " R9 pcNext"}, 32'(pcNext), 32'(expPc));
    if (ja || br) begin
      mSecond = 1'b0;
    end else if (fr) begin
      if (mSecond) begin
        mW1 = d; mBad = (d[15:12] != 4'hF); mSecond = 1'b0; expValid = 1'b1;
      end else begin
        mW0 = d; mW1 = '0; mBad = 1'b0;
        if (tw) mSecond = 1'b1; else expValid = 1'b1;
      end
    end
    mPc = expPc;
    @(posedge clk);
    #1;
    chk({tag, " R2 memAddr"}, 32'(memAddr), 32'(mPc));
    chk({tag, " R3/R4 instValid"}, 32'(instValid), 32'(expValid));
    chk({tag, " R3/R4 word0"}, 32'(word0), 32'(mW0));
    chk({tag, " R4 word1"}, 32'(word1), 32'(mW1));
    chk({tag, " R5 pairErr"}, 32'(pairErr), 32'(mBad));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 values held in reset
    chk("R1 reset memAddr", 32'(memAddr), 0);
    chk("R1 reset instValid", 32'(instValid), 0);
    chk("R1 reset words", 32'({word0, word1}), 0);
    chk("R1 reset pairErr", 32'(pairErr), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 after release memAddr", 32'(memAddr), 0);
    chk("R1 after release instValid", 32'(instValid), 0);

    // R3 R4 R10 mixed fetch runs with idle gaps
    for (int k = 0; k < 300; k++) begin
      logic [15:0] d;
      d = {((k % 5) == 0) ? 4'h3 : 4'hF, 12'(k * 613)};
      if ((k % 7) == 0) step(1'b0, 1'b0, 1'b0, 1'b0, 11'd0, d, "R10 idle");
      else step(1'b1, (k % 3) == 1, 1'b0, 1'b0, 11'd0, d, "R3 R4 fetch");
    end

    // R6 example from the requirement: EF03h, F000h -> 000006h
    step(1'b1, 1'b1, 1'b0, 1'b0, 11'd0, 16'hEF03, "R6 ex w0");
    step(1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 16'hF000, "R6 ex w1");
    step(1'b0, 1'b0, 1'b1, 1'b0, 11'd0, 16'h0, "R6 ex jump");
    chk("R6 example target", 32'(memAddr), 32'h6);

    // R6 sweep of absolute targets
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, 11'd0, {8'hEF, 8'(i * 37 + 5)}, "R6 w0");
      step(1'b1, 1'b0, 1'b0, 1'b0, 11'd0, {4'hF, 12'(i * 1234 + 77)}, "R6 w1");
      step(1'b0, 1'b0, 1'b1, 1'b0, 11'd0, 16'h0, "R6 jump");
    end

    // R7 sweep of all offsets, with wrap through zero
    step(1'b0, 1'b0, 1'b1, 1'b0, 11'd0, 16'h0, "R7 seed");
    for (int o = -1024; o < 1024; o++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, 11'(o), 16'h0, "R7 branch");
      if ((o % 97) == 0) step(1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 16'h1234, "R7 fetch");
    end

    // R8 priority and cancellation of a pending second word
    step(1'b1, 1'b1, 1'b0, 1'b0, 11'd0, 16'hAB12, "R8 pend");
    step(1'b1, 1'b0, 1'b1, 1'b1, 11'h7FF, 16'hF999, "R8 all three");
    step(1'b1, 1'b1, 1'b0, 1'b0, 11'd0, 16'h5566, "R8 first again");
    step(1'b1, 1'b0, 1'b0, 1'b1, 11'd3, 16'hF777, "R8 branch over fetch");
    step(1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 16'h4321, "R8 first after branch");
    chk("R8 fresh first word no second", 32'(word1), 0);

    finish_run();
  end

endmodule